// File: doc/BRIEF.md
# Wavetable Pitch Modulator

This block bends the pitch of a wavetable oscillator. A free-running divider produces one step opportunity every sixteen clocks. On each of these ticks an 18-bit phase accumulator adds a 12-bit modulation rate. When the low twelve bits overflow, or when the force option is set, the upper part of the accumulator advances. The entry selected by the top five accumulator bits then changes a 7-bit signed counter. The next bit down is not used for the index, so every table entry is applied on two consecutive steps.

The counter is multiplied by a 6-bit gain, rounded, centred and reduced to an 8-bit scale factor. That factor multiplies a 12-bit base pitch to give the 20-bit pitch word for the oscillator. This word is registered. Software sets the rate and the halt and force options through a single write. It fills the 32-entry ring of 3-bit codes one entry at a time while the block is halted. It can also load the counter directly. The counter and the accumulator can always be read back.

Top module: `fm_pitch_mod`

## Requirements
- R1: While reset is asserted, `cnt_o`, `acc_o` and `pitch_o` are all zero. After reset the block comes up halted, with a rate of 0 and the force option cleared.
- R2: The accumulator changes only on a divider tick, which is every 16th clock edge after reset is released. On a tick of a running block, `acc_o[11:0]` adds the rate modulo 4096.
- R3: A step occurs on a running tick whose low add carries out of bit 11. A step applies the code stored at index `acc_o[17:13]`, taken before the tick, to the counter, and then increments `acc_o[17:12]`. Each entry is therefore used on two successive steps.
- R4: The codes 0 to 7 have these effects on the counter: 0 leaves it unchanged, 1 adds 1, 2 adds 2, 3 adds 4, 4 clears it to 0, 5 subtracts 4, 6 subtracts 2 and 7 subtracts 1.
- R5: The counter is 7-bit two's complement and wraps: 63 plus 1 gives -64, and -64 minus 1 gives 63.
- R6: Writing halt = 1 clears `acc_o[12:0]` on the next edge and keeps `acc_o[17:13]`. While halted, neither the counter nor the accumulator moves on ticks.
- R7: A table write while halted stores `tbl_wdata` at index `acc_o[17:13]` and then increments that index, so 32 writes return the index to its start. A table write while running changes neither the table nor the accumulator.
- R8: With force = 1, every running tick is a step, whatever the carry.
- R9: A rate of 0 makes ticks leave the accumulator and the counter unchanged. The pitch word is still computed from the counter.
- R10: `cnt_we` loads `cnt_wdata` into the counter unchanged, and the new value is visible one edge later.
- R11: One edge after its operands, `pitch_o` equals (base × s) mod 2^20. To form s: let t = counter × gain. If t[3:0] ≠ 0 and t[11] = 0, add 32 to t. Then add 1024, and s is bits 11:4 of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_we | input | 1 | Write strobe for rate, halt and force |
| freq_wdata | input | 12 | Modulation rate added on each tick |
| halt_wdata | input | 1 | Halt option written with the rate |
| force_wdata | input | 1 | Force-step option written with the rate |
| tbl_we | input | 1 | Table append strobe (effective only while halted) |
| tbl_wdata | input | 3 | Code written to the table |
| cnt_we | input | 1 | Direct counter load strobe |
| cnt_wdata | input | 7 | Signed value for the counter |
| base_pitch | input | 12 | Unmodulated oscillator pitch |
| mod_gain | input | 6 | Modulation depth |
| pitch_o | output | 20 | Registered modulated pitch word |
| cnt_o | output | 7 | Current signed counter |
| acc_o | output | 18 | Current phase accumulator |

## Verification
Each result of this block appears at a fixed number of edges after its cause:
- A counter load, a table append and a halt are visible one edge after their strobe.
- The pitch word follows its counter, gain and base operands by one edge.
- Stepping happens only on the edges that close each 16-clock divider period.

The bench drives inputs and samples outputs on falling edges. It counts rising edges since reset so that every step check falls just after a tick edge, and each table or rate write is issued straight after a tick so that no step can land in between. The pitch sweep covers every counter value and every gain for two base pitches. Each pitch sample is taken one edge after its gain change.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

    localparam int CNT_W  = 7;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        DC_HOLD = 3'd0,
        DC_UP1  = 3'd1,
        DC_UP2  = 3'd2,
        DC_UP4  = 3'd3,
        DC_ZERO = 3'd4,
        DC_DN4  = 3'd5,
        DC_DN2  = 3'd6,
        DC_DN1  = 3'd7
    } delta_code_e;

    // Applies one table code to the wrapping signed counter.
    function automatic logic [CNT_W-1:0] apply_code(input logic [CNT_W-1:0] cur,
                                                   input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] res;
        case (delta_code_e'(code))
            DC_UP1:  res = cur + CNT_W'(1);
            DC_UP2:  res = cur + CNT_W'(2);
            DC_UP4:  res = cur + CNT_W'(4);
            DC_ZERO: res = '0;
            DC_DN4:  res = cur - CNT_W'(4);
            DC_DN2:  res = cur - CNT_W'(2);
            DC_DN1:  res = cur - CNT_W'(1);
            default: res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/fmm_tick_div.sv
module fmm_tick_div #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [DW-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == DW'(DIV - 1)) st_d.cnt = '0;
        else                          st_d.cnt = st_q.cnt + DW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = (st_q.cnt == DW'(DIV - 1));

    // R2: ticks are isolated single-cycle pulses
    p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/fmm_step_core.sv
module fmm_step_core
    import fmm_pkg::*;
#(
    parameter int FREQ_W = 12,
    parameter int IDX_W  = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic                       freq_we_i,
    input  logic [FREQ_W-1:0]          freq_wdata_i,
    input  logic                       halt_wdata_i,
    input  logic                       force_wdata_i,
    input  logic                       tbl_we_i,
    input  logic [CODE_W-1:0]          tbl_wdata_i,
    input  logic                       cnt_we_i,
    input  logic [CNT_W-1:0]           cnt_wdata_i,
    output logic [CNT_W-1:0]           cnt_o,
    output logic [FREQ_W+IDX_W:0]      acc_o
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int ACC_W = FREQ_W + 1 + IDX_W;
    localparam int UP_W  = IDX_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0]                acc;
        logic [CNT_W-1:0]                cnt;
        logic [FREQ_W-1:0]               freq;
        logic                            halt;
        logic                            force_step;
        logic [DEPTH-1:0][CODE_W-1:0]    tbl;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [IDX_W-1:0] idx;
    logic [FREQ_W:0]  low_sum;
    logic             run;
    logic             step;

    always_comb begin
        st_d    = st_q;
        idx     = st_q.acc[ACC_W-1 -: IDX_W];
        run     = tick_i && !st_q.halt && (st_q.freq != '0);
        low_sum = {1'b0, st_q.acc[FREQ_W-1:0]} + {1'b0, st_q.freq};
        step    = run && (low_sum[FREQ_W] || st_q.force_step);

        if (run) begin
            st_d.acc = {st_q.acc[ACC_W-1:FREQ_W] + UP_W'(step), low_sum[FREQ_W-1:0]};
        end
        if (step) begin
            st_d.cnt = apply_code(st_q.cnt, st_q.tbl[idx]);
        end
        if (cnt_we_i) begin
            st_d.cnt = cnt_wdata_i;
        end
        if (tbl_we_i && st_q.halt) begin
            st_d.tbl[idx]                   = tbl_wdata_i;
            st_d.acc[ACC_W-1 -: IDX_W]      = idx + IDX_W'(1);
        end
        if (freq_we_i) begin
            st_d.freq       = freq_wdata_i;
            st_d.halt       = halt_wdata_i;
            st_d.force_step = force_wdata_i;
        end
        if (st_d.halt) begin
            st_d.acc[FREQ_W:0] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.halt <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign acc_o = st_q.acc;

    // R2: without a tick the counter moves only through a direct load
    p_cnt_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_we_i) |=> $stable(cnt_o));

    // R2: without a tick or a write the accumulator holds
    p_acc_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !tbl_we_i && !freq_we_i) |=> $stable(acc_o));

    // R6: in halt the low and ghost bits stay clear
    p_halt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.halt |-> (acc_o[FREQ_W:0] == '0));

    // R7: appends while running leave the table index alone
    p_tbl_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we_i && !st_q.halt && !tick_i) |=> $stable(acc_o[ACC_W-1 -: IDX_W]));

    // R8: forced ticks always advance the upper accumulator
    p_force_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !st_q.halt && st_q.force_step && (st_q.freq != '0) && !freq_we_i)
        |=> (acc_o[ACC_W-1:FREQ_W] == $past(acc_o[ACC_W-1:FREQ_W]) + UP_W'(1)));

    // R9: a zero rate never moves the counter
    p_rate_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (st_q.freq == '0) && !cnt_we_i) |=> $stable(cnt_o));

endmodule

// File: rtl/fmm_pitch_calc.sv
module fmm_pitch_calc
    import fmm_pkg::*;
#(
    parameter int BASE_W = 12,
    parameter int GAIN_W = 6,
    parameter int FRAC_W = 4,
    parameter int SCL_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CNT_W-1:0]           cnt_i,
    input  logic [GAIN_W-1:0]          gain_i,
    input  logic [BASE_W-1:0]          base_i,
    output logic [BASE_W+SCL_W-1:0]    pitch_o
);
    localparam int WIN_W  = FRAC_W + SCL_W;
    localparam int OUT_W  = BASE_W + SCL_W;
    localparam logic [WIN_W-1:0] ROUND  = WIN_W'(1) << (FRAC_W + 1);
    localparam logic [WIN_W-1:0] CENTRE = WIN_W'(1) << (WIN_W - 2);

    typedef struct packed {
        logic [OUT_W-1:0] pitch;
    } pitch_state_t;

    pitch_state_t st_d, st_q;

    logic [WIN_W-1:0] prod;
    logic             do_round;
    logic [WIN_W-1:0] centred;
    logic [SCL_W-1:0] scale;

    always_comb begin
        st_d     = st_q;
        prod     = WIN_W'($signed(cnt_i) * $signed({1'b0, gain_i}));
        do_round = (prod[FRAC_W-1:0] != '0) && !prod[WIN_W-1];
        centred  = prod + (do_round ? ROUND : '0) + CENTRE;
        scale    = SCL_W'(centred >> FRAC_W);
        st_d.pitch = OUT_W'({{SCL_W{1'b0}}, base_i} * {{BASE_W{1'b0}}, scale});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pitch_o = st_q.pitch;

    // R11: a zero base pitch yields a zero word one edge later
    p_zero_base_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (base_i == '0) |=> (pitch_o == '0));

    // R11: zero gain gives the centred scale of 64
    p_zero_gain_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_i == '0) |=> (pitch_o == OUT_W'({$past(base_i), 6'b0})));

endmodule

// File: rtl/fm_pitch_mod.sv
module fm_pitch_mod
    import fmm_pkg::*;
#(
    parameter int FREQ_W   = 12,
    parameter int TBL_SIZE = 32,
    parameter int TICK_DIV = 16,
    parameter int GAIN_W   = 6,
    parameter int SCL_W    = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  freq_we,
    input  logic [FREQ_W-1:0]                     freq_wdata,
    input  logic                                  halt_wdata,
    input  logic                                  force_wdata,
    input  logic                                  tbl_we,
    input  logic [CODE_W-1:0]                     tbl_wdata,
    input  logic                                  cnt_we,
    input  logic [CNT_W-1:0]                      cnt_wdata,
    input  logic [FREQ_W-1:0]                     base_pitch,
    input  logic [GAIN_W-1:0]                     mod_gain,
    output logic [FREQ_W+SCL_W-1:0]               pitch_o,
    output logic [CNT_W-1:0]                      cnt_o,
    output logic [FREQ_W+$clog2(TBL_SIZE):0]      acc_o
);
    localparam int IDX_W = $clog2(TBL_SIZE);

    logic tick;

    fmm_tick_div #(.DIV(TICK_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    fmm_step_core #(.FREQ_W(FREQ_W), .IDX_W(IDX_W)) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick),
        .freq_we_i     (freq_we),
        .freq_wdata_i  (freq_wdata),
        .halt_wdata_i  (halt_wdata),
        .force_wdata_i (force_wdata),
        .tbl_we_i      (tbl_we),
        .tbl_wdata_i   (tbl_wdata),
        .cnt_we_i      (cnt_we),
        .cnt_wdata_i   (cnt_wdata),
        .cnt_o         (cnt_o),
        .acc_o         (acc_o)
    );

    fmm_pitch_calc #(.BASE_W(FREQ_W), .GAIN_W(GAIN_W), .FRAC_W(4), .SCL_W(SCL_W)) u_pitch (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_i   (cnt_o),
        .gain_i  (mod_gain),
        .base_i  (base_pitch),
        .pitch_o (pitch_o)
    );

    // R10: a direct load shows up unchanged one edge later
    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt_o == $past(cnt_wdata)));

endmodule

// File: tb/fm_pitch_mod_tb.sv
`timescale 1ns/1ps
module fm_pitch_mod_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freq_we = 1'b0;
    logic [11:0] freq_wdata = '0;
    logic        halt_wdata = 1'b0;
    logic        force_wdata = 1'b0;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_wdata = '0;
    logic        cnt_we = 1'b0;
    logic [6:0]  cnt_wdata = '0;
    logic [11:0] base_pitch = '0;
    logic [5:0]  mod_gain = '0;
    logic [19:0] pitch_o;
    logic [6:0]  cnt_o;
    logic [17:0] acc_o;

    int checks = 0;
    int errors = 0;
    int pe = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) pe <= 0;
        else        pe <= pe + 1;
    end

    fm_pitch_mod u_dut (
        .clk(clk), .rst_n(rst_n),
        .freq_we(freq_we), .freq_wdata(freq_wdata),
        .halt_wdata(halt_wdata), .force_wdata(force_wdata),
        .tbl_we(tbl_we), .tbl_wdata(tbl_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .base_pitch(base_pitch), .mod_gain(mod_gain),
        .pitch_o(pitch_o), .cnt_o(cnt_o), .acc_o(acc_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ref_pitch(input int c, input int g, input int b);
        int t;
        t = c * g;
        if ((t & 15) != 0 && (t & 'h800) == 0) t = t + 32;
        t = t + 1024;
        t = (t >>> 4) & 255;
        return (b * t) & 'hFFFFF;
    endfunction

    function automatic logic [6:0] ref_step(input logic [6:0] c, input int code);
        int d [8] = '{0, 1, 2, 4, 0, -4, -2, -1};
        if (code == 4) return 7'd0;
        return c + 7'(d[code]);
    endfunction

    task automatic wr_freq(input int f, input bit h, input bit fo);
        freq_we = 1'b1; freq_wdata = 12'(f); halt_wdata = h; force_wdata = fo;
        @(negedge clk);
        freq_we = 1'b0;
    endtask

    task automatic wr_tbl(input int v);
        tbl_we = 1'b1; tbl_wdata = 3'(v);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic ld_cnt(input int v);
        cnt_we = 1'b1; cnt_wdata = 7'(v);
        @(negedge clk);
        cnt_we = 1'b0;
    endtask

    task automatic wait_tick();
        @(negedge clk);
        while (pe % 16 != 0) @(negedge clk);
    endtask

    int pat [32];

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [6:0] m;
        int low, up, p, acc_prev, cnt_prev;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cnt", int'(cnt_o), 0);
        chk("R1 acc", int'(acc_o), 0);
        chk("R1 pitch", int'(pitch_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10/R11: every counter and gain for two base pitches
        foreach (pat[i]) pat[i] = (i * 5 + 3) % 8;
        for (int bsel = 0; bsel < 2; bsel++) begin
            base_pitch = (bsel == 0) ? 12'hFFF : 12'h5A3;
            for (int c = -64; c < 64; c++) begin
                ld_cnt(c);
                chk("R10 load", int'($signed(cnt_o)), c);
                for (int g = 0; g < 64; g++) begin
                    mod_gain = 6'(g);
                    @(negedge clk);
                    chk("R11 pitch", int'(pitch_o), ref_pitch(c, g, int'(base_pitch)));
                end
            end
        end

        // R7: fill the ring while halted (halted since reset)
        wr_tbl(pat[0]);
        chk("R7 advance", int'(acc_o), 'h2000);
        for (int i = 1; i < 32; i++) wr_tbl(pat[i]);
        chk("R7 ring wrap", int'(acc_o), 0);

        // R3/R4/R8: forced stepping, each entry used twice
        ld_cnt(5);
        m = 7'd5;
        wait_tick();
        wr_freq(1, 1'b0, 1'b1);
        for (int k = 0; k < 66; k++) begin
            wait_tick();
            m = ref_step(m, pat[(k >> 1) % 32]);
            chk("R8 force acc", int'(acc_o), (((k + 1) % 64) << 12) | (k + 1));
            chk("R3 R4 cnt", int'(cnt_o), int'(m));
        end

        // R6: halt clears low bits, keeps index, stops motion
        acc_prev = int'(acc_o);
        wr_freq(1, 1'b1, 1'b0);
        chk("R6 clear", int'(acc_o), acc_prev & 'h3E000);
        p = (acc_prev >> 13) & 31;
        cnt_prev = int'(cnt_o);
        wait_tick(); wait_tick();
        chk("R6 hold acc", int'(acc_o), p << 13);
        chk("R6 hold cnt", int'(cnt_o), cnt_prev);

        // R9: zero rate while running
        wait_tick();
        wr_freq(0, 1'b0, 1'b0);
        ld_cnt(10);
        m = 7'd10;
        wait_tick(); wait_tick(); wait_tick();
        chk("R9 acc", int'(acc_o), p << 13);
        chk("R9 cnt", int'(cnt_o), 10);
        base_pitch = 12'h321; mod_gain = 6'd20;
        @(negedge clk);
        chk("R9 pitch", int'(pitch_o), ref_pitch(10, 20, 'h321));

        // R7: append while running is ignored
        wr_tbl(4);
        chk("R7 ignored", int'(acc_o), p << 13);

        // R2/R3: carry-driven stepping with the original table
        wait_tick();
        wr_freq('h600, 1'b0, 1'b0);
        chk("R2 no tick yet", int'(acc_o), p << 13);
        repeat (8) @(negedge clk);
        chk("R2 between ticks", int'(acc_o), p << 13);
        low = 0; up = p << 1;
        for (int k = 0; k < 20; k++) begin
            wait_tick();
            low = low + 'h600;
            if (low >= 'h1000) begin
                low = low - 'h1000;
                m = ref_step(m, pat[(up >> 1) % 32]);
                up = (up + 1) % 64;
            end
            chk("R2 acc", int'(acc_o), (up << 12) | low);
            chk("R3 cnt", int'(cnt_o), int'(m));
        end

        // R5: wrap upward and downward
        wr_freq(1, 1'b1, 1'b0);
        for (int i = 0; i < 32; i++) wr_tbl(1);
        ld_cnt(63);
        wait_tick();
        wr_freq(1, 1'b0, 1'b1);
        wait_tick();
        chk("R5 up wrap", int'($signed(cnt_o)), -64);
        wr_freq(1, 1'b1, 1'b0);
        for (int i = 0; i < 32; i++) wr_tbl(7);
        ld_cnt(-64);
        wait_tick();
        wr_freq(1, 1'b0, 1'b1);
        wait_tick();
        chk("R5 down wrap", int'($signed(cnt_o)), 63);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule